// File: doc/BRIEF.md
# Configurable I2S Serial Framer

This block connects a parallel sample stream to a three-wire serial audio link made of a bit clock, a word-select line and a data line. It divides the system clock down to produce the bit clock. It drives word select so that left and right slots alternate, starting with left. On transmit it shifts each sample out. On receive it rebuilds each sample from the incoming data line and presents it with a channel tag.

Configuration is static while the link runs:
- The slot length and the sample length are set separately. A sample shorter than its slot can sit at either end of the slot.
- The bit order can be chosen.
- The word-select level that marks the left channel can be chosen.
- The divider value sets the bit rate.

There is a clock gate and a synchronous channel reset. Transmit and receive each have their own enable. A transmit slot that finds no sample waiting sends zeros and flags an underrun.

Top module: `i2s_framer`

## Requirements
- R1: While `rstN` is low, `chanReset` is high or `clkEnable` is low, the block is idle. In the cycle after, `sck`=0, `sdOut`=0, `ws` shows the left level, and `txReady`=0, `rxValid`=0. The first slot after leaving idle is a left slot.
- R2: While `clkEnable` is high, `sck` toggles every `cfgDivisor`+1 system clocks, so one bit period is 2*(`cfgDivisor`+1) clocks. While `clkEnable` is low, `sck` stays 0.
- R3: `ws` equals `cfgWsLeftHigh` during left-channel slots and its inverse during right-channel slots. `ws` changes only on a falling `sck` edge, and it does so one bit period before the first bit of the next slot.
- R4: `sdOut` changes only together with a falling `sck` edge (or on entry to idle). Data is sampled on the rising edge.
- R5: A slot holds `cfgWordLen`+1 bits and a sample holds `cfgSampleLen`+1 bits; each field is encoded as its value minus one. A sample length greater than the slot length is clipped to the slot length.
- R6: With `cfgJustifyLsb`=0 the sample fills the first N bit positions of the slot. With `cfgJustifyLsb`=1 it fills the last N positions. Every other transmitted position is 0.
- R7: With `cfgLsbFirst`=0 the sample is sent most significant bit first. With 1 it is sent least significant bit first. Sample bit 0 is `txData[0]`.
- R8: When `txEnable` is high, `txReady` pulses for one cycle in the cycle of the falling edge that starts a slot. That slot sends the sample on `txData` if `txValid` is high in that cycle.
- R9: If `txValid` is low when `txReady` pulses, `txUnderrun` pulses in the same cycle and the whole slot sends zeros.
- R10: While `txEnable` is low, `txReady` and `txUnderrun` stay 0 and every transmitted bit is 0.
- R11: Received bits outside the sample positions are ignored. After the rising edge of the last bit of a slot, `rxValid` rises with the sample in `rxData[N-1:0]` (upper bits 0) and `rxRight`=1 for a right slot. `rxValid` holds until `rxReady` is high.
- R12: A slot delivers a received sample only if `rxEnable` was high at that slot's start and at its last bit. With `rxEnable` low, `rxValid` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| chanReset | input | 1 | Synchronous channel reset to idle |
| clkEnable | input | 1 | Enables bit-clock generation |
| txEnable | input | 1 | Transmit direction enable |
| rxEnable | input | 1 | Receive direction enable |
| cfgWordLen | input | 5 | Slot length minus one |
| cfgSampleLen | input | 5 | Sample length minus one |
| cfgJustifyLsb | input | 1 | 1: sample at the end of the slot |
| cfgLsbFirst | input | 1 | 1: least significant bit first |
| cfgWsLeftHigh | input | 1 | Word-select level marking left |
| cfgDivisor | input | 16 | Bit-clock half period minus one, in clocks |
| txData | input | 32 | Transmit sample |
| txValid | input | 1 | Transmit sample present |
| txReady | output | 1 | Transmit sample taken this cycle |
| txUnderrun | output | 1 | Slot started with no sample |
| rxData | output | 32 | Received sample, right aligned |
| rxValid | output | 1 | Received sample present |
| rxRight | output | 1 | Received sample came from the right slot |
| rxReady | input | 1 | Consumer takes the received sample |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select |
| sdOut | output | 1 | Serial data out |
| sdIn | input | 1 | Serial data in |

## Verification
The assertions check these edge relationships on every cycle:
- the data and word-select lines move only with a falling bit-clock edge;
- the bit clock stays low when gated;
- ready and underrun pulses fall on slot-starting edges, and an underrun forces a zero bit;
- a disabled transmitter emits zeros;
- a received sample appears only on a rising edge and stays until it is taken.

Only the bench scenarios can show the slot contents, which run through a loopback and a serial decoder. These cover bit placement for each justification and bit order, sample clipping, the ws-derived slot length, left-first ordering, the measured bit period, and the effect of channel reset and of each enable.

// File: rtl/i2s_framer_pkg.sv
package i2s_framer_pkg;
  // Timing strobes from control to datapath, all single-cycle.
  typedef struct packed {
    logic idle;       // block held idle this cycle
    logic rise;       // sck rises at this edge
    logic fall;       // sck falls at this edge
    logic lastBit;    // current bit is the final bit of its slot
    logic armed;      // current slot may deliver a received sample
    logic slotStart;  // falling edge that begins a new slot
    logic slotEnd;    // rising edge of the last bit of an armed slot
    logic curRight;   // current bit belongs to the right slot
  } strobe_t;
endpackage

// File: rtl/i2s_framer_ctrl.sv
module i2s_framer_ctrl
  import i2s_framer_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanReset,
  input  logic             clkEnable,
  input  logic             rxEnable,
  input  logic [IDX_W-1:0] cfgWordLen,
  input  logic [DIV_W-1:0] cfgDivisor,
  output logic             sck,
  output logic             wsRight,
  output logic [IDX_W-1:0] curIdx,
  output logic [IDX_W-1:0] nextIdx,
  output strobe_t          strobes
);
  logic             idle;
  logic             tick;
  logic             lastBit;
  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             slotRight;
  logic             rxArmed;

  assign idle    = chanReset | ~clkEnable;
  assign tick    = rstN & ~idle & (divCnt >= cfgDivisor);
  assign lastBit = bitIdx >= cfgWordLen;

  // Idle parks the bit counter on the last bit of a right slot,
  // so the first falling edge opens a left slot.
  always_ff @(posedge clk) begin
    if (!rstN || idle) begin
      divCnt    <= '0;
      sck       <= 1'b0;
      bitIdx    <= cfgWordLen;
      slotRight <= 1'b1;
      rxArmed   <= 1'b0;
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) sck <= ~sck;
      if (tick && sck) begin
        if (lastBit) begin
          bitIdx    <= '0;
          slotRight <= ~slotRight;
          rxArmed   <= rxEnable;
        end else begin
          bitIdx <= bitIdx + 1'b1;
        end
      end
    end
  end

  assign curIdx  = bitIdx;
  assign nextIdx = lastBit ? '0 : bitIdx + 1'b1;
  // Word select announces the channel of the following bit.
  assign wsRight = lastBit ? ~slotRight : slotRight;

  always_comb begin
    strobes           = '0;
    strobes.idle      = idle | ~rstN;
    strobes.rise      = tick & ~sck;
    strobes.fall      = tick & sck;
    strobes.lastBit   = lastBit;
    strobes.armed     = rxArmed;
    strobes.slotStart = tick & sck & lastBit;
    strobes.slotEnd   = tick & ~sck & lastBit & rxArmed;
    strobes.curRight  = slotRight;
  end
endmodule

// File: rtl/i2s_framer_dp.sv
module i2s_framer_dp
  import i2s_framer_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int IDX_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobes,
  input  logic [IDX_W-1:0]    curIdx,
  input  logic [IDX_W-1:0]    nextIdx,
  input  logic [IDX_W-1:0]    cfgWordLen,
  input  logic [IDX_W-1:0]    cfgSampleLen,
  input  logic                cfgJustifyLsb,
  input  logic                cfgLsbFirst,
  input  logic                txEnable,
  input  logic                rxEnable,
  input  logic [SAMPLE_W-1:0] txData,
  input  logic                txValid,
  output logic                txReady,
  output logic                txUnderrun,
  output logic                sdOut,
  input  logic                sdIn,
  output logic [SAMPLE_W-1:0] rxData,
  output logic                rxValid,
  output logic                rxRight,
  input  logic                rxReady
);
  logic [IDX_W-1:0]    sampLast;
  logic [IDX_W:0]      sampStart;
  logic [SAMPLE_W-1:0] txHold;
  logic [SAMPLE_W-1:0] txWord;
  logic [SAMPLE_W-1:0] txFresh;
  logic [IDX_W:0]      txMap;
  logic [IDX_W:0]      rxMap;
  logic                txBit;
  logic [SAMPLE_W-1:0] rxAcc;
  logic [SAMPLE_W-1:0] rxNext;

  assign sampLast  = (cfgSampleLen > cfgWordLen) ? cfgWordLen : cfgSampleLen;
  assign sampStart = cfgJustifyLsb ? ({1'b0, cfgWordLen} - {1'b0, sampLast}) : '0;

  // Maps a slot position to {inSample, sampleBitIndex}.
  function automatic logic [IDX_W:0] mapPos(input logic [IDX_W-1:0] pos);
    logic [IDX_W:0]   k;
    logic [IDX_W-1:0] sel;
    k = {1'b0, pos} - sampStart;
    if (({1'b0, pos} >= sampStart) && (k <= {1'b0, sampLast})) begin
      sel = cfgLsbFirst ? k[IDX_W-1:0] : (sampLast - k[IDX_W-1:0]);
      return {1'b1, sel};
    end
    return '0;
  endfunction

  // Transmit side
  assign txReady    = strobes.slotStart & txEnable;
  assign txUnderrun = txReady & ~txValid;
  assign txFresh    = (txEnable && txValid) ? txData : '0;
  assign txWord     = strobes.slotStart ? txFresh : txHold;
  assign txMap      = mapPos(nextIdx);
  assign txBit      = txEnable & txMap[IDX_W] & txWord[txMap[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rstN || strobes.idle) begin
      txHold <= '0;
      sdOut  <= 1'b0;
    end else if (strobes.fall) begin
      if (strobes.slotStart) txHold <= txFresh;
      sdOut <= txBit;
    end
  end

  // Receive side
  assign rxMap = mapPos(curIdx);
  always_comb begin
    rxNext = rxAcc;
    if (rxMap[IDX_W]) rxNext[rxMap[IDX_W-1:0]] = sdIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.idle) begin
      rxAcc   <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
      rxRight <= 1'b0;
    end else begin
      if (rxValid && rxReady) rxValid <= 1'b0;
      if (strobes.rise && strobes.armed && rxEnable) begin
        if (strobes.lastBit) begin
          rxAcc <= '0;
          if (strobes.slotEnd) begin
            rxData  <= rxNext;
            rxValid <= 1'b1;
            rxRight <= strobes.curRight;
          end
        end else begin
          rxAcc <= rxNext;
        end
      end else if (strobes.rise && strobes.lastBit) begin
        rxAcc <= '0;
      end
    end
  end

  p_tx_off_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.fall) && !$past(txEnable)) |-> !sdOut);

  p_rx_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady && !strobes.idle && !strobes.slotEnd) |=> rxValid);
endmodule

// File: rtl/i2s_framer.sv
module i2s_framer
  import i2s_framer_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int DIV_W    = 16,
  localparam int IDX_W   = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                chanReset,
  input  logic                clkEnable,
  input  logic                txEnable,
  input  logic                rxEnable,
  input  logic [IDX_W-1:0]    cfgWordLen,
  input  logic [IDX_W-1:0]    cfgSampleLen,
  input  logic                cfgJustifyLsb,
  input  logic                cfgLsbFirst,
  input  logic                cfgWsLeftHigh,
  input  logic [DIV_W-1:0]    cfgDivisor,
  input  logic [SAMPLE_W-1:0] txData,
  input  logic                txValid,
  output logic                txReady,
  output logic                txUnderrun,
  output logic [SAMPLE_W-1:0] rxData,
  output logic                rxValid,
  output logic                rxRight,
  input  logic                rxReady,
  output logic                sck,
  output logic                ws,
  output logic                sdOut,
  input  logic                sdIn
);
  strobe_t          strobes;
  logic [IDX_W-1:0] curIdx;
  logic [IDX_W-1:0] nextIdx;
  logic             wsRight;

  i2s_framer_ctrl #(.IDX_W(IDX_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .chanReset(chanReset), .clkEnable(clkEnable),
    .rxEnable(rxEnable), .cfgWordLen(cfgWordLen), .cfgDivisor(cfgDivisor),
    .sck(sck), .wsRight(wsRight), .curIdx(curIdx), .nextIdx(nextIdx),
    .strobes(strobes)
  );

  i2s_framer_dp #(.SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .curIdx(curIdx), .nextIdx(nextIdx),
    .cfgWordLen(cfgWordLen), .cfgSampleLen(cfgSampleLen),
    .cfgJustifyLsb(cfgJustifyLsb), .cfgLsbFirst(cfgLsbFirst),
    .txEnable(txEnable), .rxEnable(rxEnable), .txData(txData), .txValid(txValid),
    .txReady(txReady), .txUnderrun(txUnderrun), .sdOut(sdOut), .sdIn(sdIn),
    .rxData(rxData), .rxValid(rxValid), .rxRight(rxRight), .rxReady(rxReady)
  );

  assign ws = wsRight ^ cfgWsLeftHigh;

  p_sck_gated_r2: assert property (@(posedge clk) disable iff (!rstN)
    !clkEnable |=> !sck);

  p_ws_on_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(ws) && $stable(cfgWsLeftHigh) && $stable(cfgWordLen)
     && !$past(chanReset) && $past(clkEnable)) |-> $fell(sck));

  p_sd_on_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdOut) |-> ($fell(sck) || $past(chanReset) || !$past(clkEnable)));

  p_ready_on_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    txReady |=> $fell(sck));

  p_underrun_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    txUnderrun |=> !sdOut);

  p_rx_on_rise_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxValid) |-> $rose(sck));

  p_rx_enabled_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxValid) |-> $past(rxEnable));
endmodule

// File: tb/i2s_framer_bench.sv
`timescale 1ns/1ps
module i2s_framer_bench;
  typedef struct packed {
    logic [4:0]  wl;
    logic [4:0]  sl;
    logic        just;
    logic        lsbF;
    logic        pol;
    logic [15:0] div;
    logic [31:0] left;
    logic [31:0] right;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{5'd15, 5'd15, 1'b0, 1'b0, 1'b0, 16'd1, 32'h0000A5C3, 32'h00001234},
    '{5'd31, 5'd23, 1'b0, 1'b0, 1'b0, 16'd0, 32'h00ABCDEF, 32'h00123456},
    '{5'd31, 5'd23, 1'b1, 1'b1, 1'b1, 16'd2, 32'h00F0A551, 32'h003C0FFE},
    '{5'd7,  5'd4,  1'b1, 1'b0, 1'b0, 16'd0, 32'h00000015, 32'h0000000A},
    '{5'd23, 5'd23, 1'b0, 1'b1, 1'b1, 16'd0, 32'h00800001, 32'h007FFFFE},
    '{5'd7,  5'd15, 1'b0, 1'b0, 1'b0, 16'd0, 32'h0000ABC3, 32'h0000005A},
    '{5'd1,  5'd0,  1'b1, 1'b0, 1'b0, 16'd0, 32'h00000001, 32'h00000000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0, chanReset = 1'b0, clkEnable = 1'b0, txEnable = 1'b0, rxEnable = 1'b0;
  logic [4:0] cfgWordLen = 5'd15, cfgSampleLen = 5'd15;
  logic cfgJustifyLsb = 1'b0, cfgLsbFirst = 1'b0, cfgWsLeftHigh = 1'b0;
  logic [15:0] cfgDivisor = 16'd0;
  logic [31:0] txData = '0;
  logic txValid = 1'b0, rxReady = 1'b1;
  logic txReady, txUnderrun, rxValid, rxRight, sck, ws, sdOut;
  logic [31:0] rxData;

  always #4 clk = ~clk;

  i2s_framer u_i2s_framer (
    .clk(clk), .rstN(rstN), .chanReset(chanReset), .clkEnable(clkEnable),
    .txEnable(txEnable), .rxEnable(rxEnable), .cfgWordLen(cfgWordLen),
    .cfgSampleLen(cfgSampleLen), .cfgJustifyLsb(cfgJustifyLsb),
    .cfgLsbFirst(cfgLsbFirst), .cfgWsLeftHigh(cfgWsLeftHigh), .cfgDivisor(cfgDivisor),
    .txData(txData), .txValid(txValid), .txReady(txReady), .txUnderrun(txUnderrun),
    .rxData(rxData), .rxValid(rxValid), .rxRight(rxRight), .rxReady(rxReady),
    .sck(sck), .ws(ws), .sdOut(sdOut), .sdIn(sdOut)
  );

  int checks = 0, fails = 0;
  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Serial monitor: decodes slots from sck/ws/sdOut, sampled at negedge.
  logic monClr = 1'b0;
  logic sckPrev, wsPrevRise, fallSeen, sdSeen;
  logic [31:0] capBits;
  int capCnt, slotNum, rxNum, underCnt, readyCnt, cyc, lastRise, risePeriod;
  logic [31:0] slotBits [4];
  int          slotLen  [4];
  logic        slotR    [4];
  logic [31:0] rxQ      [4];
  logic        rxRQ     [4];

  always @(negedge clk) begin
    cyc++;
    if (!rstN || monClr) begin
      sckPrev = 1'b0; wsPrevRise = ws; fallSeen = 1'b0; sdSeen = 1'b0;
      capBits = '0; capCnt = 0; slotNum = 0; rxNum = 0; underCnt = 0; readyCnt = 0;
      lastRise = cyc; risePeriod = 0;
    end else begin
      if (!sckPrev && sck) begin
        risePeriod = cyc - lastRise;
        lastRise = cyc;
        if (fallSeen) begin
          if (capCnt < 32) capBits[capCnt] = sdOut;
          capCnt++;
          if (ws != wsPrevRise) begin
            if (slotNum < 4) begin
              slotBits[slotNum] = capBits;
              slotLen[slotNum]  = capCnt;
              slotR[slotNum]    = (wsPrevRise != cfgWsLeftHigh);
            end
            slotNum++;
            capCnt = 0; capBits = '0;
          end
        end
        wsPrevRise = ws;
      end
      if (sckPrev && !sck) fallSeen = 1'b1;
      if (sdOut) sdSeen = 1'b1;
      if (txUnderrun) underCnt++;
      if (txReady) readyCnt++;
      if (rxValid && rxReady) begin
        if (rxNum < 4) begin rxQ[rxNum] = rxData; rxRQ[rxNum] = rxRight; end
        rxNum++;
      end
      sckPrev = sck;
    end
  end

  function automatic int effLen(input vec_t v);
    return (v.sl > v.wl) ? int'(v.wl) + 1 : int'(v.sl) + 1;
  endfunction

  // Expected slot pattern: bit p of the result is slot position p.
  function automatic logic [31:0] expSlot(input vec_t v, input logic [31:0] s);
    int w = int'(v.wl) + 1;
    int n = effLen(v);
    int off = v.just ? w - n : 0;
    logic [31:0] r = '0;
    for (int p = 0; p < w; p++) begin
      if (p >= off && p < off + n) r[p] = v.lsbF ? s[p - off] : s[n - 1 - (p - off)];
    end
    return r;
  endfunction

  function automatic logic [31:0] expRx(input vec_t v, input logic [31:0] s);
    int n = effLen(v);
    return (n == 32) ? s : (s & ((32'd1 << n) - 1));
  endfunction

  task automatic applyCfg(input vec_t v);
    cfgWordLen = v.wl; cfgSampleLen = v.sl; cfgJustifyLsb = v.just;
    cfgLsbFirst = v.lsbF; cfgWsLeftHigh = v.pol; cfgDivisor = v.div;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic waitReady();
    int t = 0;
    do begin @(negedge clk); t++; end while (!txReady && t < 5000);
  endtask

  task automatic waitSlots(input int n);
    int t = 0;
    while ((slotNum < n) && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic waitRx(input int n);
    int t = 0;
    while ((rxNum < n) && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    clkEnable = 1'b1; txEnable = 1'b1; rxEnable = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!sck && !sdOut && !txReady && !rxValid, "R1 reset outputs", {28'd0, sck, sdOut, txReady, rxValid}, 32'd0);
    check(ws == cfgWsLeftHigh, "R1 ws idle left", {31'd0, ws}, {31'd0, cfgWsLeftHigh});

    // Vector table: loopback, two samples per vector
    for (int i = 0; i < NVEC; i++) begin
      vec_t v = VECS[i];
      applyCfg(v);
      txValid = 1'b0;
      doReset();
      txData = v.left; txValid = 1'b1;
      waitReady();
      @(posedge clk); #1 txData = v.right;
      waitReady();
      @(posedge clk); #1 txValid = 1'b0;
      waitSlots(2);
      waitRx(2);
      check(slotLen[0] == int'(v.wl) + 1, "R3/R5 slot length", slotLen[0], int'(v.wl) + 1);
      check(!slotR[0], "R1/R3 first slot left", {31'd0, slotR[0]}, 32'd0);
      check(slotR[1], "R3 second slot right", {31'd0, slotR[1]}, 32'd1);
      check(slotBits[0] == expSlot(v, v.left), "R6/R7 left serial", slotBits[0], expSlot(v, v.left));
      check(slotBits[1] == expSlot(v, v.right), "R6/R7 right serial", slotBits[1], expSlot(v, v.right));
      check(rxQ[0] == expRx(v, v.left) && !rxRQ[0], "R11 rx left", rxQ[0], expRx(v, v.left));
      check(rxQ[1] == expRx(v, v.right) && rxRQ[1], "R11 rx right", rxQ[1], expRx(v, v.right));
    end

    // R2: bit period with divisor 3
    applyCfg(VECS[0]); cfgDivisor = 16'd3;
    doReset();
    waitCycles(60);
    check(risePeriod == 8, "R2 bit period", risePeriod, 32'd8);

    // R2: gated clock stays low
    clkEnable = 1'b0;
    waitCycles(2);
    begin
      logic sawHigh = 1'b0;
      for (int k = 0; k < 30; k++) begin @(negedge clk); if (sck) sawHigh = 1'b1; end
      check(!sawHigh, "R2 sck gated", {31'd0, sawHigh}, 32'd0);
    end
    clkEnable = 1'b1; cfgDivisor = 16'd0;

    // R9: underrun sends zeros
    txEnable = 1'b1; txValid = 1'b0;
    doReset();
    waitSlots(1);
    check(underCnt >= 1, "R9 underrun pulse", underCnt, 32'd1);
    check(slotBits[0] == 32'd0, "R9 zero slot", slotBits[0], 32'd0);

    // R10: transmit disabled
    txEnable = 1'b0; txValid = 1'b1; txData = 32'hFFFFFFFF;
    doReset();
    waitSlots(3);
    check(readyCnt == 0 && underCnt == 0, "R10 no ready or underrun", readyCnt + underCnt, 32'd0);
    check(!sdSeen, "R10 data stays zero", {31'd0, sdSeen}, 32'd0);

    // R12: receive disabled
    txEnable = 1'b1; rxEnable = 1'b0;
    doReset();
    waitSlots(3);
    check(rxNum == 0 && !rxValid, "R12 no rx sample", rxNum, 32'd0);

    // R11: rxValid held while consumer not ready
    rxEnable = 1'b1; rxReady = 1'b0;
    doReset();
    waitSlots(1);
    waitCycles(3);
    check(rxValid == 1'b1, "R11 rxValid raised", {31'd0, rxValid}, 32'd1);
    waitCycles(20);
    check(rxValid == 1'b1, "R11 rxValid held", {31'd0, rxValid}, 32'd1);
    rxReady = 1'b1;

    // R1: channel reset mid-frame
    waitCycles(11);
    @(posedge clk); #1 chanReset = 1'b1;
    @(posedge clk); #1 chanReset = 1'b0;
    @(negedge clk);
    check(!sck && !sdOut && !rxValid, "R1 chanReset idle", {29'd0, sck, sdOut, rxValid}, 32'd0);
    check(ws == cfgWsLeftHigh, "R1 chanReset ws left", {31'd0, ws}, {31'd0, cfgWsLeftHigh});

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule